// File: doc/BRIEF.md
# Skid-Buffered Gain Stage with Registered Ready

This block is one stage of a streaming pipeline. Words enter with a valid strobe and leave with a valid strobe. Each side has a ready signal for flow control. Every word accepted is multiplied by a constant gain, set by a parameter, and then written into a small first-in first-out buffer. The output side presents the head of that buffer.

The ready signal sent upstream comes from a flop, so the producer always sees the stage's readiness one cycle late. To cover that lag, the stage lowers ready while it still has two free slots. A word that the producer launches in the cycle after ready falls therefore still has a place to land.

A producer that ignores ready can still drive words into a full buffer. Such a word is discarded. A sticky overflow flag and a saturating drop counter record every discard, so the loss can be seen at the ports.

Top module: `rrs_stage`

## Requirements
- R1: `out_data` equals the accepted input word multiplied by `GAIN`, zero-extended to `OUT_W` bits (defaults: `GAIN`=3, `IN_W`=8, `OUT_W`=12).
- R2: Words leave in exactly the order in which they were stored.
- R3: A word presented while `in_valid` and `in_ready` are both high is always stored and never counted as dropped.
- R4: `in_ready` is a registered signal. It is high in a cycle exactly when the buffer held at most `DEPTH`-2 words after the previous clock edge; otherwise it is low (default `DEPTH`=4).
- R5: A word presented in the first cycle after `in_ready` falls is still stored.
- R6: `out_valid` is high whenever the buffer is non-empty. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R7: A word presented while the buffer is full and no word leaves in the same cycle is discarded. `ovf_flag` then goes high and stays high until reset.
- R8: `drop_count` increases by one for each discarded word and stops at its all-ones value (15 for `CNT_W`=4).
- R9: A synchronous active-high `rst` empties the buffer and clears `ovf_flag` and `drop_count`. It holds `in_ready` low during reset and for the first cycle after reset.
- R10: When the buffer is full and a word leaves in the same cycle, a word presented in that cycle is stored, not dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | IN_W | Upstream data word |
| in_valid | input | 1 | Upstream word present |
| in_ready | output | 1 | Registered readiness returned upstream |
| out_data | output | OUT_W | Scaled word at buffer head |
| out_valid | output | 1 | Buffer head holds a fresh word |
| out_ready | input | 1 | Downstream can take the head word |
| ovf_flag | output | 1 | Sticky: at least one word discarded |
| drop_count | output | CNT_W | Saturating count of discarded words |

## Verification
The hardest state to reach is a full buffer that receives another word. A producer that obeys ready never gets there, because the slack of two slots absorbs the single word still in flight. The stimulus therefore plays a producer that ignores ready. It keeps `in_valid` high with `out_ready` low, through the cycle where ready falls, into the in-flight slot and then past it. It then pops and pushes in the same cycle on a full buffer, and finally drives more than fifteen discards to reach counter saturation.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    // Per-cycle flow decision shared between the control and storage logic.
    typedef struct packed {
        logic push;   // word written into the buffer this cycle
        logic pop;    // head word consumed this cycle
        logic drop;   // word presented but discarded this cycle
    } flow_t;

endpackage

// File: rtl/rrs_gain.sv
module rrs_gain #(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned OUT_W = 12,
    parameter int unsigned GAIN  = 3
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);

    always_comb begin
        dout = OUT_W'(din) * OUT_W'(GAIN);
    end

endmodule

// File: rtl/rrs_flow_ctrl.sv
module rrs_flow_ctrl
    import rrs_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned LW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          out_ready,
    input  logic [LW-1:0] level,
    output flow_t         flow,
    output logic          in_ready
);

    localparam logic [LW-1:0] FULL_LVL  = LW'(DEPTH);
    localparam logic [LW:0]   RDY_LIMIT = (LW+1)'(DEPTH - 2);

    typedef struct packed {
        logic rdy;
    } ctl_t;

    ctl_t        ctl_d, ctl_q;
    logic        room;
    logic [LW:0] lvl_next;

    always_comb begin
        flow.pop  = (level != '0) && out_ready;
        room      = (level != FULL_LVL) || flow.pop;
        flow.push = in_valid && room;
        flow.drop = in_valid && !room;

        lvl_next  = {1'b0, level} + (LW+1)'(flow.push) - (LW+1)'(flow.pop);

        ctl_d     = ctl_q;
        ctl_d.rdy = (lvl_next <= RDY_LIMIT);
        if (rst) begin
            ctl_d.rdy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign in_ready = ctl_q.rdy;

endmodule

// File: rtl/rrs_buffer.sv
module rrs_buffer #(
    parameter int unsigned W     = 12,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned LW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] lvl;
    } ptr_t;

    ptr_t         ptr_d, ptr_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (push) begin
            ptr_d.wr = (ptr_q.wr == LAST) ? '0 : ptr_q.wr + 1'b1;
        end
        if (pop) begin
            ptr_d.rd = (ptr_q.rd == LAST) ? '0 : ptr_q.rd + 1'b1;
        end
        ptr_d.lvl = ptr_q.lvl + LW'(push) - LW'(pop);
        if (rst) begin
            ptr_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push && !rst) begin
            mem_q[ptr_q.wr] <= wdata;
        end
    end

    assign rdata = mem_q[ptr_q.rd];
    assign level = ptr_q.lvl;

endmodule

// File: rtl/rrs_drop_counter.sv
module rrs_drop_counter #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          drop,
    output logic [CW-1:0] count,
    output logic          flag
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovf;
    } drp_t;

    drp_t drp_d, drp_q;

    always_comb begin
        drp_d = drp_q;
        if (drop) begin
            drp_d.ovf = 1'b1;
            if (drp_q.cnt != '1) begin
                drp_d.cnt = drp_q.cnt + 1'b1;
            end
        end
        if (rst) begin
            drp_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        drp_q <= drp_d;
    end

    assign count = drp_q.cnt;
    assign flag  = drp_q.ovf;

endmodule

// File: rtl/rrs_stage.sv
module rrs_stage
    import rrs_pkg::*;
#(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned OUT_W = 12,
    parameter int unsigned GAIN  = 3,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             ovf_flag,
    output logic [CNT_W-1:0] drop_count
);

    localparam int unsigned LW = $clog2(DEPTH + 1);

    flow_t            flow;
    logic [OUT_W-1:0] scaled;
    logic [LW-1:0]    buf_level;
    logic             drop_evt;

    rrs_gain #(.IN_W(IN_W), .OUT_W(OUT_W), .GAIN(GAIN)) u_gain (
        .din  (in_data),
        .dout (scaled)
    );

    rrs_flow_ctrl #(.DEPTH(DEPTH), .LW(LW)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .level     (buf_level),
        .flow      (flow),
        .in_ready  (in_ready)
    );

    rrs_buffer #(.W(OUT_W), .DEPTH(DEPTH), .LW(LW)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .push  (flow.push),
        .pop   (flow.pop),
        .wdata (scaled),
        .rdata (out_data),
        .level (buf_level)
    );

    assign drop_evt = flow.drop;

    rrs_drop_counter #(.CW(CNT_W)) u_drop (
        .clk   (clk),
        .rst   (rst),
        .drop  (drop_evt),
        .count (drop_count),
        .flag  (ovf_flag)
    );

    assign out_valid = (buf_level != '0);

endmodule

// File: rtl/rrs_stage_chk.sv
module rrs_stage_chk #(
    parameter int unsigned OUT_W = 12,
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [OUT_W-1:0] out_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic             ovf_flag,
    input logic [CNT_W-1:0] drop_count,
    input logic             drop_evt
);

    AST_ACCEPT_KEPT: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |-> !drop_evt); // R3

    AST_INFLIGHT_KEPT: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) && in_valid |-> !drop_evt); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag); // R7

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        drop_evt |=> ovf_flag); // R7

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        drop_evt && (drop_count != '1) |=> drop_count == CNT_W'($past(drop_count) + 1'b1)); // R8

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
        drop_count == '1 |=> drop_count == '1); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !in_ready && !out_valid && !ovf_flag && (drop_count == '0)); // R9

endmodule

bind rrs_stage rrs_stage_chk #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .ovf_flag   (ovf_flag),
    .drop_count (drop_count),
    .drop_evt   (drop_evt)
);

// File: tb/tb_rrs_stage.sv
`timescale 1ns/1ps
module tb_rrs_stage;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        ovf_flag;
    logic [3:0]  drop_count;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    rrs_stage dut (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .ovf_flag   (ovf_flag),
        .drop_count (drop_count)
    );

    typedef struct packed {
        logic        iv;
        logic [7:0]  din;
        logic        ordy;
        logic        e_rdy;
        logic        e_ov;
        logic [11:0] e_od;
        logic [3:0]  e_drops;
        logic        e_flag;
    } vec_t;

    // Expected fields describe the state seen before the row's inputs take effect.
    localparam vec_t VECS [12] = '{
        '{1'b1, 8'd1,   1'b0, 1'b0, 1'b0, 12'd0,   4'd0, 1'b0},
        '{1'b1, 8'd2,   1'b0, 1'b1, 1'b1, 12'd3,   4'd0, 1'b0},
        '{1'b1, 8'd5,   1'b0, 1'b1, 1'b1, 12'd3,   4'd0, 1'b0},
        '{1'b1, 8'd7,   1'b0, 1'b0, 1'b1, 12'd3,   4'd0, 1'b0},
        '{1'b1, 8'd9,   1'b0, 1'b0, 1'b1, 12'd3,   4'd0, 1'b0},
        '{1'b1, 8'd10,  1'b1, 1'b0, 1'b1, 12'd3,   4'd1, 1'b1},
        '{1'b0, 8'd0,   1'b1, 1'b0, 1'b1, 12'd6,   4'd1, 1'b1},
        '{1'b0, 8'd0,   1'b1, 1'b0, 1'b1, 12'd15,  4'd1, 1'b1},
        '{1'b0, 8'd0,   1'b1, 1'b1, 1'b1, 12'd21,  4'd1, 1'b1},
        '{1'b1, 8'd255, 1'b1, 1'b1, 1'b1, 12'd30,  4'd1, 1'b1},
        '{1'b0, 8'd0,   1'b1, 1'b1, 1'b1, 12'd765, 4'd1, 1'b1},
        '{1'b0, 8'd0,   1'b0, 1'b1, 1'b0, 12'd0,   4'd1, 1'b1}
    };

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic drive(input logic iv, input logic [7:0] d, input logic ordy);
        in_valid  = iv;
        in_data   = d;
        out_ready = ordy;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9 ready low in reset", int'(in_ready), 0);
        chk("R9 empty in reset", int'(out_valid), 0);
        rst = 1'b0;

        // Vector table: fill, in-flight word, overflow, pop+push on full, drain.
        for (int i = 0; i < 12; i++) begin
            chk($sformatf("R4/R9 row %0d in_ready", i), int'(in_ready), int'(VECS[i].e_rdy));
            chk($sformatf("R6 row %0d out_valid", i), int'(out_valid), int'(VECS[i].e_ov));
            if (VECS[i].e_ov) begin
                chk($sformatf("R1/R2/R5/R10 row %0d out_data", i), int'(out_data), int'(VECS[i].e_od));
            end
            chk($sformatf("R8 row %0d drop_count", i), int'(drop_count), int'(VECS[i].e_drops));
            chk($sformatf("R7 row %0d ovf_flag", i), int'(ovf_flag), int'(VECS[i].e_flag));
            drive(VECS[i].iv, VECS[i].din, VECS[i].ordy);
            @(negedge clk);
        end

        // R3: a word accepted under ready is never dropped (drop count unchanged).
        drive(1'b1, 8'd40, 1'b0);
        @(negedge clk);
        chk("R3 accepted under ready", int'(drop_count), 1);
        drive(1'b0, 8'd0, 1'b1);
        @(negedge clk);
        drive(1'b0, 8'd0, 1'b0);
        chk("R3 stored word drained", int'(out_valid), 0);

        // R8 saturation: fill four words, then 20 more while stalled.
        for (int k = 0; k < 4; k++) begin
            drive(1'b1, 8'(11 + k), 1'b0);
            @(negedge clk);
        end
        for (int k = 0; k < 20; k++) begin
            drive(1'b1, 8'd99, 1'b0);
            @(negedge clk);
        end
        drive(1'b0, 8'd0, 1'b0);
        chk("R8 saturated count", int'(drop_count), 15);
        chk("R7 flag after drops", int'(ovf_flag), 1);
        chk("R4 ready low when full", int'(in_ready), 0);
        @(negedge clk);
        chk("R6 stalled head held", int'(out_data), 33);
        chk("R6 stalled valid held", int'(out_valid), 1);

        // R2 drain order.
        drive(1'b0, 8'd0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            chk($sformatf("R2 drain word %0d", k), int'(out_data), (11 + k) * 3);
            @(negedge clk);
        end
        drive(1'b0, 8'd0, 1'b0);
        chk("R6 empty after drain", int'(out_valid), 0);
        chk("R4 ready after drain", int'(in_ready), 1);

        // R9 mid-stream reset.
        drive(1'b1, 8'd50, 1'b0);
        @(negedge clk);
        @(negedge clk);
        drive(1'b0, 8'd0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 ready low after reset", int'(in_ready), 0);
        chk("R9 buffer emptied", int'(out_valid), 0);
        chk("R9 count cleared", int'(drop_count), 0);
        chk("R9 flag cleared", int'(ovf_flag), 0);
        @(negedge clk);
        chk("R9 ready returns", int'(in_ready), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule